// File: doc/BRIEF.md
# DMA Interrupt Status and Global Control Register Bank

This block is the shared status and control register bank of an eight-channel DMA engine. Each channel reports two kinds of single-cycle event: a terminal-count event, raised when a transfer finishes, and an error event. The bank latches every event into a sticky raw bit. It holds a per-channel mask bit for each event class, which software writes through that channel's configuration word. It derives masked status for each class and a combined per-channel status from them. It drives one interrupt line, together with the index of the lowest-numbered channel that has an unmasked pending event, so the handler can service channels in fixed priority order.

Software reads and writes the bank over a simple word bus. A write is a single-cycle strobe. A read is a single-cycle strobe, and the read data is registered and returned one cycle later with a valid flag. Pending bits are cleared by writing ones to the clear addresses. The bank also shows which channels are currently active, and holds the global controller enable and the byte-order selects for the two bus masters.

Top module: `dmairq_ctrl`

## Requirements
- R1: A terminal-count pulse on channel n sets bit n of the raw terminal-count register (offset 0x14). The bit stays set until it is cleared, whatever the mask.
- R2: An error pulse on channel n sets bit n of the raw error register (offset 0x18). The bit stays set until it is cleared, whatever the mask.
- R3: Channel n's configuration word sits at offset 0x100 + 0x20*n + 0x10. Its bit 15 is the terminal-count mask and its bit 14 is the error mask. The masked terminal-count status (0x04) and the masked error status (0x0C) are the raw bits ANDed with those masks.
- R4: Writing to offset 0x08 clears the raw terminal-count bits at the positions where the data has a one. Offset 0x10 does the same for the raw error bits. Bits written as zero are not changed, and writing 0xFF clears all eight bits.
- R5: When a new event and a clear of the same bit fall in the same cycle, the bit stays set.
- R6: Bit n of the combined status (offset 0x00) is the OR of the two masked bits of channel n. The irq output is high whenever any combined bit is set.
- R7: irq_ch gives the lowest-numbered channel whose combined bit is set, so channel 0 has the highest priority. It is 0 when nothing is pending.
- R8: The global config word (offset 0x30) holds bit 0 = controller enable, bit 1 = master 1 byte order and bit 2 = master 2 byte order, where 0 means little-endian and 1 means big-endian. The stored bits drive ctrl_en, m1_big_end and m2_big_end, and the other bits read as zero.
- R9: Offset 0x1C returns the ch_active input as it was sampled in the read cycle.
- R10: Reads of the clear offsets return zero, and writes to the status offsets (0x00, 0x04, 0x0C, 0x14, 0x18, 0x1C) change nothing.
- R11: After reset, all status, masks and global config bits are zero, and irq and irq_ch are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| rdata_vld | output | 1 | rdata holds a valid read result |
| tc_evt | input | 8 | Terminal-count event pulses, one per channel |
| err_evt | input | 8 | Error event pulses, one per channel |
| ch_active | input | 8 | Active flags of the channels |
| irq | output | 1 | Combined interrupt request |
| irq_ch | output | 3 | Highest-priority pending channel |
| ctrl_en | output | 1 | Global controller enable |
| m1_big_end | output | 1 | Master 1 byte order, 1 = big-endian |
| m2_big_end | output | 1 | Master 2 byte order, 1 = big-endian |

## Verification
A raw bit that is lost or set wrongly shows up in the next read of the raw offset. If its mask is set, it also shows on irq and irq_ch in the cycle after the event. A mask latch that points at the wrong channel changes the masked reads and the priority index at once. A clear that decodes the wrong address, or loses to an event in the wrong order, leaves a stale bit or drops a bit, and the next status read shows it. The scoreboard reads every status view after each stimulus, so a wrong internal state is reported within a few cycles of its cause.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned DATA_W   = 32;

  localparam logic [ADDR_W-1:0] OFS_COMB    = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_TC_MSK  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_TC_CLR  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_ER_MSK  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_ER_CLR  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_TC_RAW  = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_ER_RAW  = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_ACTIVE  = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_GCFG    = 12'h030;

  localparam int unsigned CH_BASE     = 'h100;
  localparam int unsigned CH_STRIDE_B = 5;      // log2 of 0x20
  localparam int unsigned CH_CFG_OFS  = 'h10;
  localparam int unsigned ERR_MBIT    = 14;
  localparam int unsigned TC_MBIT     = 15;

  typedef enum logic [1:0] {
    GCFG_EN  = 2'd0,
    GCFG_M1  = 2'd1,
    GCFG_M2  = 2'd2
  } gcfg_bit_e;

  typedef struct packed {
    logic m2_big;
    logic m1_big;
    logic en;
  } gcfg_t;
endpackage

// File: rtl/dmairq_evt_bank.sv
module dmairq_evt_bank #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] evt,
  input  logic           clr_we,
  input  logic [NCH-1:0] clr_bits,
  input  logic [NCH-1:0] mask,
  output logic [NCH-1:0] raw,
  output logic [NCH-1:0] masked
);
  logic [NCH-1:0] raw_q;
  logic [NCH-1:0] raw_d;
  logic           raw_ce;

  // events take priority over a simultaneous clear
  always_comb begin
    raw_d  = raw_q;
    raw_ce = 1'b0;
    if (clr_we) begin
      raw_d  = raw_d & ~clr_bits;
      raw_ce = 1'b1;
    end
    if (|evt) begin
      raw_d  = raw_d | evt;
      raw_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      raw_q <= '0;
    else if (raw_ce)
      raw_q <= raw_d;
  end

  assign raw    = raw_q;
  assign masked = raw_q & mask;
endmodule

// File: rtl/dmairq_chan_masks.sv
module dmairq_chan_masks #(
  parameter int unsigned NCH    = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NCH-1:0]    tc_mask,
  output logic [NCH-1:0]    err_mask,
  output logic              hit,
  output logic [DATA_W-1:0] rd_word
);
  import dmairq_pkg::*;

  localparam int unsigned CH_W   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned SPAN   = NCH << CH_STRIDE_B;
  localparam int unsigned STR    = 1 << CH_STRIDE_B;

  logic [ADDR_W-1:0] rel;
  logic              in_range;
  logic [CH_W-1:0]   sel;

  assign rel      = addr - ADDR_W'(CH_BASE);
  assign in_range = (addr >= ADDR_W'(CH_BASE)) && (int'(rel) < SPAN);
  assign hit      = in_range && (rel[CH_STRIDE_B-1:0] == CH_STRIDE_B'(CH_CFG_OFS));
  assign sel      = rel[CH_STRIDE_B +: CH_W];

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      logic we_d;
      logic tc_q, er_q;
      assign we_d = wr_en && hit && (int'(sel) == g);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tc_q <= 1'b0;
          er_q <= 1'b0;
        end else if (we_d) begin
          tc_q <= wdata[TC_MBIT];
          er_q <= wdata[ERR_MBIT];
        end
      end
      assign tc_mask[g]  = tc_q;
      assign err_mask[g] = er_q;
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    rd_word[TC_MBIT]  = tc_mask[sel];
    rd_word[ERR_MBIT] = err_mask[sel];
  end

  logic unused_bits;
  assign unused_bits = ^{STR[0]};
endmodule

// File: rtl/dmairq_prio_enc.sv
module dmairq_prio_enc #(
  parameter int unsigned NCH = 8
) (
  input  logic [NCH-1:0]                            req,
  output logic                                      any,
  output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0]  idx
);
  localparam int unsigned IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  // scan from the top down so the lowest index is the last to win
  always_comb begin
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl #(
  parameter int unsigned NCH    = 8,
  parameter int unsigned ADDR_W = dmairq_pkg::ADDR_W,
  parameter int unsigned DATA_W = dmairq_pkg::DATA_W,
  localparam int unsigned CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_vld,
  input  logic [NCH-1:0]    tc_evt,
  input  logic [NCH-1:0]    err_evt,
  input  logic [NCH-1:0]    ch_active,
  output logic              irq,
  output logic [CH_W-1:0]   irq_ch,
  output logic              ctrl_en,
  output logic              m1_big_end,
  output logic              m2_big_end
);
  import dmairq_pkg::*;

  logic [NCH-1:0] tc_raw, tc_mskd, err_raw, err_mskd;
  logic [NCH-1:0] tc_msk, err_msk, comb_sts;
  logic           tc_clr_we, err_clr_we;
  logic           cfg_hit;
  logic [DATA_W-1:0] cfg_word;

  assign tc_clr_we  = wr_en && (addr == OFS_TC_CLR);
  assign err_clr_we = wr_en && (addr == OFS_ER_CLR);

  dmairq_evt_bank #(.NCH(NCH)) u_tc_bank (
    .clk(clk), .rst_n(rst_n), .evt(tc_evt),
    .clr_we(tc_clr_we), .clr_bits(wdata[NCH-1:0]),
    .mask(tc_msk), .raw(tc_raw), .masked(tc_mskd)
  );

  dmairq_evt_bank #(.NCH(NCH)) u_err_bank (
    .clk(clk), .rst_n(rst_n), .evt(err_evt),
    .clr_we(err_clr_we), .clr_bits(wdata[NCH-1:0]),
    .mask(err_msk), .raw(err_raw), .masked(err_mskd)
  );

  dmairq_chan_masks #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_masks (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .tc_mask(tc_msk), .err_mask(err_msk), .hit(cfg_hit), .rd_word(cfg_word)
  );

  assign comb_sts = tc_mskd | err_mskd;

  dmairq_prio_enc #(.NCH(NCH)) u_prio (
    .req(comb_sts), .any(irq), .idx(irq_ch)
  );

  // global configuration
  gcfg_t gcfg_q, gcfg_d;
  logic  gcfg_ce;

  always_comb begin
    gcfg_ce = wr_en && (addr == OFS_GCFG);
    gcfg_d  = gcfg_q;
    if (gcfg_ce) begin
      gcfg_d.en     = wdata[GCFG_EN];
      gcfg_d.m1_big = wdata[GCFG_M1];
      gcfg_d.m2_big = wdata[GCFG_M2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gcfg_q <= '0;
    else if (gcfg_ce)
      gcfg_q <= gcfg_d;
  end

  assign ctrl_en    = gcfg_q.en;
  assign m1_big_end = gcfg_q.m1_big;
  assign m2_big_end = gcfg_q.m2_big;

  // read path
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              vld_q;

  always_comb begin
    rd_mux = '0;
    if (cfg_hit) begin
      rd_mux = cfg_word;
    end else begin
      case (addr)
        OFS_COMB:   rd_mux[NCH-1:0] = comb_sts;
        OFS_TC_MSK: rd_mux[NCH-1:0] = tc_mskd;
        OFS_ER_MSK: rd_mux[NCH-1:0] = err_mskd;
        OFS_TC_RAW: rd_mux[NCH-1:0] = tc_raw;
        OFS_ER_RAW: rd_mux[NCH-1:0] = err_raw;
        OFS_ACTIVE: rd_mux[NCH-1:0] = ch_active;
        OFS_GCFG:   rd_mux[2:0]     = gcfg_q;
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (rd_en)
      rdata_q <= rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      vld_q <= 1'b0;
    else
      vld_q <= rd_en;
  end

  assign rdata     = rdata_q;
  assign rdata_vld = vld_q;
endmodule

// File: rtl/dmairq_ctrl_chk.sv
module dmairq_ctrl_chk #(
  parameter int unsigned NCH    = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CH_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NCH-1:0]    tc_evt,
  input logic [NCH-1:0]    tc_msk,
  input logic [NCH-1:0]    tc_raw,
  input logic [NCH-1:0]    comb_sts,
  input logic              irq,
  input logic [CH_W-1:0]   irq_ch,
  input logic              ctrl_en,
  input logic              m1_big_end,
  input logic              m2_big_end,
  input logic [DATA_W-1:0] rdata
);
  import dmairq_pkg::*;

  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == OFS_TC_CLR) |=> ((tc_raw & $past(tc_raw)) == $past(tc_raw))); // R1

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_evt != '0) |=> ((tc_raw & $past(tc_evt)) == $past(tc_evt))); // R5

  AST_UNMASKED_EVT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (((tc_evt & tc_msk) != '0) && !wr_en) |=> irq); // R6

  AST_IDLE_CH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (irq_ch == '0)); // R7

  AST_CH_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> comb_sts[irq_ch]); // R7

  AST_GCFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == OFS_GCFG) |=> $stable({ctrl_en, m1_big_end, m2_big_end})); // R8

  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == OFS_TC_CLR || addr == OFS_ER_CLR)) |=> (rdata == '0)); // R10
endmodule

bind dmairq_ctrl dmairq_ctrl_chk #(
  .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .tc_evt(tc_evt), .tc_msk(tc_msk), .tc_raw(tc_raw), .comb_sts(comb_sts),
  .irq(irq), .irq_ch(irq_ch), .ctrl_en(ctrl_en), .m1_big_end(m1_big_end),
  .m2_big_end(m2_big_end), .rdata(rdata)
);

// File: tb/dmairq_ctrl_tb_top.sv
module dmairq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rdata_vld;
  logic [7:0]  tc_evt = '0, err_evt = '0, ch_active = '0;
  logic        irq;
  logic [2:0]  irq_ch;
  logic        ctrl_en, m1_big_end, m2_big_end;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  dmairq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld), .tc_evt(tc_evt),
    .err_evt(err_evt), .ch_active(ch_active), .irq(irq), .irq_ch(irq_ch),
    .ctrl_en(ctrl_en), .m1_big_end(m1_big_end), .m2_big_end(m2_big_end)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pop one expected item per returned read
  always @(negedge clk) begin
    if (rst_n && rdata_vld) begin
      if (exp_q.size() == 0) begin
        chk("read-without-request", 32'h1, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, rdata, e);
      end
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(logic [7:0] tc, logic [7:0] er);
    @(negedge clk);
    tc_evt = tc; err_evt = er;
    @(negedge clk);
    tc_evt = '0; err_evt = '0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 irq", {31'd0, irq}, 32'd0);
    chk("R11 irq_ch", {29'd0, irq_ch}, 32'd0);
    rd(12'h000, 32'h0, "R11 comb");
    rd(12'h014, 32'h0, "R11 tc raw");
    rd(12'h018, 32'h0, "R11 err raw");
    rd(12'h030, 32'h0, "R11 gcfg");
    rd(12'h150, 32'h0, "R11 ch2 cfg");

    // R9 active channels
    ch_active = 8'hA5;
    rd(12'h01C, 32'hA5, "R9 active");

    // R1 raw set with masks off, R3 masked stays clear
    pulse(8'h24, 8'h00);
    rd(12'h014, 32'h24, "R1 tc raw");
    rd(12'h004, 32'h00, "R3 tc masked off");
    chk("R3 irq masked", {31'd0, irq}, 32'd0);

    // R3 set tc mask of channel 2
    wr(12'h150, 32'h0000_8000);
    rd(12'h150, 32'h0000_8000, "R3 ch2 cfg");
    rd(12'h004, 32'h04, "R3 tc masked");
    rd(12'h000, 32'h04, "R6 comb");
    chk("R6 irq", {31'd0, irq}, 32'd1);
    chk("R7 irq_ch=2", {29'd0, irq_ch}, 32'd2);

    // R7 a higher index does not override
    wr(12'h1B0, 32'h0000_8000);
    chk("R7 irq_ch still 2", {29'd0, irq_ch}, 32'd2);

    // R2 error raw, R3 error mask ch7
    pulse(8'h00, 8'h80);
    rd(12'h018, 32'h80, "R2 err raw");
    rd(12'h00C, 32'h00, "R3 err masked off");
    wr(12'h1F0, 32'h0000_4000);
    rd(12'h00C, 32'h80, "R3 err masked");
    rd(12'h000, 32'hA4, "R6 comb mixed");

    // R7 channel 0 error wins priority
    wr(12'h110, 32'h0000_4000);
    pulse(8'h00, 8'h01);
    chk("R7 irq_ch=0", {29'd0, irq_ch}, 32'd0);

    // R4 partial clear of errors
    wr(12'h010, 32'h0000_0001);
    rd(12'h018, 32'h80, "R4 err partial clear");
    chk("R4 irq_ch back to 2", {29'd0, irq_ch}, 32'd2);

    // R10 writes to status ignored, clear reads zero
    wr(12'h014, 32'h0);
    wr(12'h000, 32'h0);
    rd(12'h014, 32'h24, "R10 raw write ignored");
    rd(12'h008, 32'h0, "R10 clear reads zero");
    rd(12'h010, 32'h0, "R10 err clear reads zero");

    // R5 event and clear in the same cycle
    @(negedge clk);
    tc_evt = 8'h04; wr_en = 1'b1; addr = 12'h008; wdata = 32'hFF;
    @(negedge clk);
    tc_evt = '0; wr_en = 1'b0;
    rd(12'h014, 32'h04, "R5 event beats clear");

    // R4 clear all
    wr(12'h008, 32'hFF);
    wr(12'h010, 32'hFF);
    rd(12'h000, 32'h0, "R4 all cleared");
    chk("R4 irq low", {31'd0, irq}, 32'd0);
    chk("R7 idle index", {29'd0, irq_ch}, 32'd0);

    // R8 global config
    wr(12'h030, 32'h7);
    chk("R8 outputs 111", {29'd0, ctrl_en, m1_big_end, m2_big_end}, 32'h7);
    rd(12'h030, 32'h7, "R8 read 111");
    wr(12'h030, 32'h5);
    chk("R8 outputs en,m2", {29'd0, ctrl_en, m1_big_end, m2_big_end}, 32'h5);
    wr(12'h030, 32'hFFFF_FFF8);
    rd(12'h030, 32'h0, "R8 upper bits ignored");

    repeat (4) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 32'd0);
    report();
  end
endmodule